// File: doc/BRIEF.md
# Error-Driven Domain Voltage Controller

This block runs a closed loop over the supply voltage codes of several voltage domains of an on-chip network. Each domain groups a few routers. The clock frequency stays fixed throughout. Every domain reports timing-error events, one possible event per cycle, taken from the network's existing error handling. The controller counts these events per domain over a fixed-length epoch. At each epoch boundary it decides, for each domain on its own, whether the code rises, holds, or falls.

A domain that saw more errors than the threshold is raised by a fixed step. A domain that saw few errors is lowered by a step that halves after each decrease. Each domain therefore closes in on its own lowest safe code. After a set number of epochs a global nudge lowers every eligible domain by one code and reloads all step sizes. This restarts the search so that it can follow drift in temperature and workload. The threshold, clamps, initial step and raise step come in as configuration inputs. The regulators and the error detectors sit outside the block.

Top module: `vdd_error_tracker`

## Requirements
- R1: While reset is asserted and just after release, every domain code equals INIT_CODE (default 200), the step of each domain equals its initial value, and all error counts are zero.
- R2: `epoch_tick_o` is high for exactly one cycle in every EPOCH_CYC cycles, first in cycle EPOCH_CYC-1 after reset release. A domain code changes only in the cycle that follows such a boundary cycle.
- R3: When a domain's error count for the epoch is greater than `err_thresh_i`, its code rises by `up_step_i` at the boundary, saturating at `code_max_i`. This takes priority over every other action.
- R4: When the count is not above threshold, no hold is pending and the boundary is not a nudge boundary, the code falls by the current step, saturating at `code_min_i`. The step then halves. The step equals max(`step_init_i` >> k, 1), where k is the number of such decreases since the last reload.
- R5: The per-domain error count saturates at 2^CNT_W-1 and never wraps. An error on the boundary cycle itself counts toward the closing epoch. The count restarts from zero after every boundary.
- R6: Every NUDGE_EPOCHS-th boundary is a nudge boundary. On it, each domain that neither rises nor holds falls by exactly one code, saturating at `code_min_i`. Every domain's step reloads to `step_init_i`, including domains that rise or hold.
- R7: The boundary right after a raise makes no decrease of any kind for that domain. The code stays put unless that epoch's count again exceeds the threshold.
- R8: Domains are independent: errors on one domain never change the code, step or hold state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | NUM_DOM | One timing-error event per domain per cycle |
| err_thresh_i | input | CNT_W | Count above which a domain is raised |
| code_min_i | input | CODE_W | Lower clamp of every code |
| code_max_i | input | CODE_W | Upper clamp of every code |
| step_init_i | input | CODE_W | Initial and reloaded decrease step |
| up_step_i | input | CODE_W | Fixed raise amount |
| code_o | output | NUM_DOM*CODE_W | Per-domain voltage codes, domain d at bits d*CODE_W upward |
| epoch_tick_o | output | 1 | High in the last cycle of each epoch |

## Verification
The hardest cases to reach from the ports are the ones where several rules meet on one boundary. These include a raise landing on a nudge boundary, a hold epoch that coincides with a nudge, and a count that saturates in the same cycle the epoch closes. Directed epochs use per-domain error quotas of exactly the threshold, the threshold plus one, and every cycle. A later mid-run jump of the raise step drives a domain into its upper clamp. A long random phase with a different error probability per domain then lets raises, holds and nudges overlap on shared boundaries. A cycle-accurate model in the bench predicts every code.

// File: rtl/vt_pkg.sv
package vt_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_UP    = 2'd1,
    ACT_DOWN  = 2'd2,
    ACT_NUDGE = 2'd3
  } vt_act_e;
endpackage

// File: rtl/vt_epoch_timer.sv
module vt_epoch_timer #(
  parameter int unsigned EPOCH_CYC    = 64,
  parameter int unsigned NUDGE_EPOCHS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic nudge_o
);
  localparam int unsigned EW = (EPOCH_CYC > 2) ? $clog2(EPOCH_CYC) : 1;
  localparam int unsigned NW = (NUDGE_EPOCHS > 2) ? $clog2(NUDGE_EPOCHS) : 1;
  localparam logic [EW-1:0] EP_LAST = EW'(EPOCH_CYC - 1);
  localparam logic [NW-1:0] ND_LAST = NW'(NUDGE_EPOCHS - 1);

  logic [EW-1:0] ep_q;
  logic [NW-1:0] nd_q;

  assign tick_o  = (ep_q == EP_LAST);
  assign nudge_o = tick_o && (nd_q == ND_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ep_q <= '0;
      nd_q <= '0;
    end else begin
      ep_q <= tick_o ? '0 : ep_q + 1'b1;
      if (tick_o) nd_q <= (nd_q == ND_LAST) ? '0 : nd_q + 1'b1;
    end
  end

  a_r2_single_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/vt_err_count.sv
module vt_err_count #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  // count including this cycle's event, saturating
  assign cnt_o = (err_i && (cnt_q != CNT_MAX)) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= clr_i ? '0 : cnt_o;
  end

  a_r5_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) && !clr_i |=> cnt_q == CNT_MAX);
  a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q <= CNT_W'(1));
endmodule

// File: rtl/vt_dom_ctrl.sv
module vt_dom_ctrl
  import vt_pkg::*;
#(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned INIT_CODE = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              nudge_i,
  input  logic              over_i,
  input  logic [CODE_W-1:0] code_min_i,
  input  logic [CODE_W-1:0] code_max_i,
  input  logic [CODE_W-1:0] step_init_i,
  input  logic [CODE_W-1:0] up_step_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned SHW = $clog2(CODE_W + 1);
  localparam logic [SHW-1:0] SH_MAX = SHW'(CODE_W);

  logic [CODE_W-1:0] code_q, code_d, step_eff, dec_amt;
  logic [SHW-1:0]    sh_q;
  logic              hold_q;
  logic [CODE_W:0]   sum, diff;
  vt_act_e           act;

  assign step_eff = ((step_init_i >> sh_q) == '0) ? CODE_W'(1) : (step_init_i >> sh_q);

  always_comb begin
    act = ACT_NONE;
    if (tick_i) begin
      if (over_i)       act = ACT_UP;
      else if (hold_q)  act = ACT_NONE;
      else if (nudge_i) act = ACT_NUDGE;
      else              act = ACT_DOWN;
    end
  end

  assign dec_amt = (act == ACT_NUDGE) ? CODE_W'(1) : step_eff;
  assign sum     = {1'b0, code_q} + {1'b0, up_step_i};
  assign diff    = {1'b0, code_q} - {1'b0, dec_amt};

  always_comb begin
    code_d = code_q;
    unique case (act)
      ACT_UP: code_d = (sum > {1'b0, code_max_i}) ? code_max_i : sum[CODE_W-1:0];
      ACT_DOWN, ACT_NUDGE:
        code_d = (diff[CODE_W] || (diff[CODE_W-1:0] < code_min_i)) ? code_min_i
                                                                   : diff[CODE_W-1:0];
      default: code_d = code_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= CODE_W'(INIT_CODE);
      sh_q   <= '0;
      hold_q <= 1'b0;
    end else begin
      code_q <= code_d;
      if (tick_i) hold_q <= over_i;
      if (tick_i && nudge_i)                         sh_q <= '0;
      else if ((act == ACT_DOWN) && (sh_q != SH_MAX)) sh_q <= sh_q + 1'b1;
    end
  end

  assign code_o = code_q;

  a_r2_epoch_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(code_q));
  a_r3_raise_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && over_i |=> code_q >= $past(code_q));
  a_r4_fall_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !over_i |=> code_q <= $past(code_q));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && hold_q && !over_i |=> $stable(code_q));
  a_r4_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q != $past(code_q) |-> (code_q >= code_min_i) && (code_q <= code_max_i));
endmodule

// File: rtl/vdd_error_tracker.sv
module vdd_error_tracker #(
  parameter int unsigned NUM_DOM      = 4,
  parameter int unsigned CODE_W       = 8,
  parameter int unsigned CNT_W        = 6,
  parameter int unsigned EPOCH_CYC    = 6250,
  parameter int unsigned NUDGE_EPOCHS = 16,
  parameter int unsigned INIT_CODE    = 200
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_DOM-1:0]        err_i,
  input  logic [CNT_W-1:0]          err_thresh_i,
  input  logic [CODE_W-1:0]         code_min_i,
  input  logic [CODE_W-1:0]         code_max_i,
  input  logic [CODE_W-1:0]         step_init_i,
  input  logic [CODE_W-1:0]         up_step_i,
  output logic [NUM_DOM*CODE_W-1:0] code_o,
  output logic                      epoch_tick_o
);
  logic tick, nudge;

  vt_epoch_timer #(
    .EPOCH_CYC   (EPOCH_CYC),
    .NUDGE_EPOCHS(NUDGE_EPOCHS)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick),
    .nudge_o(nudge)
  );

  assign epoch_tick_o = tick;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic [CNT_W-1:0] cnt;
    logic             over;

    vt_err_count #(.CNT_W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .err_i (err_i[d]),
      .clr_i (tick),
      .cnt_o (cnt)
    );

    assign over = cnt > err_thresh_i;

    vt_dom_ctrl #(
      .CODE_W   (CODE_W),
      .INIT_CODE(INIT_CODE)
    ) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .nudge_i    (nudge),
      .over_i     (over),
      .code_min_i (code_min_i),
      .code_max_i (code_max_i),
      .step_init_i(step_init_i),
      .up_step_i  (up_step_i),
      .code_o     (code_o[d*CODE_W +: CODE_W])
    );
  end
endmodule

// File: tb/vdd_error_tracker_tb_top.sv
`timescale 1ns/1ps
module vdd_error_tracker_tb_top;
  localparam int ND = 4, CW = 8, NW = 4, EP = 16, NE = 6, INIT = 200;
  localparam int CMAX = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ND-1:0] err = '0;
  logic [NW-1:0] thr = 4'd3;
  logic [CW-1:0] cmin = 8'd40, cmax = 8'd220, sinit = 8'd32, upst = 8'd8;
  logic [ND*CW-1:0] code;
  logic tick;

  always #4 clk = ~clk;

  vdd_error_tracker #(.NUM_DOM(ND), .CODE_W(CW), .CNT_W(NW), .EPOCH_CYC(EP),
                      .NUDGE_EPOCHS(NE), .INIT_CODE(INIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .err_i(err), .err_thresh_i(thr),
    .code_min_i(cmin), .code_max_i(cmax), .step_init_i(sinit), .up_step_i(upst),
    .code_o(code), .epoch_tick_o(tick));

  int checks = 0, fails = 0;
  bit done = 0;
  int m_code[ND], m_sh[ND], m_cnt[ND], m_sent[ND], quota[ND], prob[ND];
  bit m_hold[ND];
  string tag[ND];
  int cyc = 0, nticks = 0;

  function automatic int step_of(int si, int sh);
    int s = si >> sh;
    return (s == 0) ? 1 : s;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // one cycle: check at negedge, drive, advance model, step edge
  task automatic one_cycle();
    bit exp_tick, nudge, over;
    int eff;
    for (int d = 0; d < ND; d++) chk(tag[d], code[d*CW +: CW], m_code[d]);
    exp_tick = (cyc % EP) == EP - 1;
    chk("R2", tick, exp_tick);
    for (int d = 0; d < ND; d++) begin
      if (quota[d] >= 0) err[d] = (m_sent[d] < quota[d]);
      else               err[d] = ($urandom % 100) < prob[d];
      m_sent[d]++;
    end
    nudge = exp_tick && ((nticks % NE) == NE - 1);
    for (int d = 0; d < ND; d++) begin
      eff = m_cnt[d] + err[d];
      if (eff > CMAX) eff = CMAX;
      if (exp_tick) begin
        over = eff > int'(thr);
        if (over) begin
          m_code[d] += int'(upst);
          if (m_code[d] > int'(cmax)) m_code[d] = cmax;
          tag[d] = (eff == CMAX) ? "R5" : "R3";
        end else if (m_hold[d]) begin
          tag[d] = "R7";
        end else if (nudge) begin
          m_code[d] -= 1;
          if (m_code[d] < int'(cmin)) m_code[d] = cmin;
          tag[d] = "R6";
        end else begin
          m_code[d] -= step_of(sinit, m_sh[d]);
          if (m_code[d] < int'(cmin)) m_code[d] = cmin;
          if (m_sh[d] < CW) m_sh[d]++;
          tag[d] = "R4";
        end
        m_hold[d] = over;
        if (nudge) m_sh[d] = 0;
        m_cnt[d] = 0;
        m_sent[d] = 0;
      end else begin
        m_cnt[d] = eff;
      end
    end
    if (exp_tick) nticks++;
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic run_epochs(int n);
    for (int i = 0; i < n * EP; i++) one_cycle();
  endtask

  task automatic set_quota(int q0, int q1, int q2, int q3);
    quota[0] = q0; quota[1] = q1; quota[2] = q2; quota[3] = q3;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int d = 0; d < ND; d++) begin
      m_code[d] = INIT; m_sh[d] = 0; m_cnt[d] = 0; m_sent[d] = 0;
      m_hold[d] = 0; tag[d] = "R1"; quota[d] = 0; prob[d] = 0;
    end
    repeat (3) @(negedge clk);
    for (int d = 0; d < ND; d++) chk("R1", code[d*CW +: CW], INIT);
    rst_n = 1'b1;
    for (int d = 0; d < ND; d++) chk("R1", code[d*CW +: CW], INIT);
    chk("R1", tick, 0);
    // R4/R6: error-free search down to the lower clamp, nudges included
    set_quota(0, 0, 0, 0);
    run_epochs(16);
    // R3: quota thr+1 raises; R5: every cycle saturates; R8: others unaffected
    set_quota(3, 4, 16, 0);
    run_epochs(1);
    // R7: domain 1 now clean, must hold one epoch
    set_quota(3, 0, 16, 0);
    run_epochs(3);
    // R3 clamp: large raise step drives domain 2 into code_max
    upst = 8'd100;
    run_epochs(3);
    upst = 8'd8;
    // mixed random traffic
    for (int d = 0; d < ND; d++) begin quota[d] = -1; prob[d] = 5 + 12 * d; end
    run_epochs(40);
    set_quota(0, 0, 0, 0);
    run_epochs(8);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule